// File: doc/BRIEF.md
# Seven-Segment Digit Decoder with Ripple Zero Suppression

This block turns a four-bit BCD digit into drive levels for the seven segments of one display character, plus its decimal point. It is meant to be placed once per digit of a multi-digit readout. Adjacent digits are linked through a ripple-blanking chain, so that zeros at the leading (or trailing) end of a number go dark while significant zeros stay visible.

The ripple link between digits is a wired-AND node. It is modelled here as two signals: this digit's own request to pull the node low, and an input that shows whether anything outside is pulling it low. The node is high only when neither pulls. A low node always blanks this digit, so an outside open-collector driver can use it as a blanking input. A separate forced-blank input overrides everything. It has no state behind it, so toggling it at any duty cycle dims the digit in proportion. The whole block is combinational.

Top module: `segdig_rb`

## Requirements
- R1: With nothing blanking the digit, codes 0 to 9 light the segments as follows, with bit 0 = segment a up to bit 6 = segment g, active high: 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F, 9=7'h6F.
- R2: Codes 10 to 15 light no segment. They are not treated as zero: `ripple_pull` stays low for them.
- R3: When `blank_force` is high, `seg` is 0, `dp_on` is 0, `ripple_pull` is 1 and `ripple_out` is 0, whatever the other inputs are.
- R4: When `digit_code` is 0 and `ripple_in` is low, the digit is fully dark and `ripple_pull` is 1.
- R5: When `digit_code` is not 0, `ripple_in` has no effect on any output.
- R6: In every other case `ripple_pull` is 0. With `ripple_pull_ext` low, `ripple_out` is then 1.
- R7: `ripple_out` is 1 only when both `ripple_pull` and `ripple_pull_ext` are 0. Whenever `ripple_out` is 0, including a low caused only by `ripple_pull_ext`, `seg` and `dp_on` are 0.
- R8: `dp_on` is 1 exactly when `dp_req` is 1 and `ripple_out` is 1.
- R9: The block holds no state. Every output follows its inputs in the same cycle, so toggling `blank_force` on every cycle alternates the outputs on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit_code | input | 4 | BCD digit to display |
| blank_force | input | 1 | High: overriding blank of the whole digit |
| ripple_in | input | 1 | Low: blank this digit if its code is zero |
| dp_req | input | 1 | High: request the decimal point |
| ripple_pull_ext | input | 1 | High: an outside driver is pulling the ripple node low |
| seg | output | 7 | Segments a..g, bit 0 = a, active high |
| dp_on | output | 1 | Decimal point drive, active high |
| ripple_pull | output | 1 | This digit's own request to pull the ripple node low |
| ripple_out | output | 1 | Resolved ripple node level, fed to the next digit's `ripple_in` |

## Verification
The hardest case to reach is a low on the ripple node that this digit did not cause. In that case `ripple_pull` stays 0, yet the digit must still go dark and lose its decimal point. The stimulus reaches it by raising `ripple_pull_ext` while the code is non-zero and `dp_req` is high. It also does so in combination with forced blanking. The chain behaviour only appears when several instances are wired together. The bench therefore builds a four-digit chain whose `ripple_out` signals feed the next `ripple_in`, and applies numbers with one, two and three leading zeros, an all-zero number, and a number with no leading zero.

// File: rtl/segdig_pkg.sv
`timescale 1ns/1ps
package segdig_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [CODE_W-1:0] code_t;

  // Segment pattern for a code, bit 0 = a .. bit 6 = g.
  function automatic seg_t code_to_seg(input code_t c);
    seg_t s;
    case (c)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D; // with tail
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F; // with tail
      default: s = '0;    // codes above nine are dark
    endcase
    return s;
  endfunction

  function automatic logic code_is_zero(input code_t c);
    return (c == '0);
  endfunction
endpackage

// File: rtl/segdig_decode.sv
`timescale 1ns/1ps
module segdig_decode
  import segdig_pkg::*;
(
  input  code_t code,
  output seg_t  raw_seg,
  output logic  zero_code
);
  assign raw_seg   = code_to_seg(code);
  assign zero_code = code_is_zero(code);

  // R2: a code above nine never yields a lit segment
  always_comb begin
    if (code > code_t'(MAX_DIGIT))
      a_r2_invalid_dark: assert (raw_seg == '0 && !zero_code);
  end
endmodule

// File: rtl/segdig_ripple.sv
`timescale 1ns/1ps
module segdig_ripple (
  input  logic force_blank,
  input  logic chain_in,
  input  logic zero_code,
  input  logic ext_pull,
  output logic own_pull,
  output logic node_level
);
  logic suppress_zero;

  assign suppress_zero = zero_code && !chain_in;
  assign own_pull      = force_blank || suppress_zero;
  // wired-AND: the node stays high only while nobody pulls
  assign node_level    = !(own_pull || ext_pull);

  // R5: on a non-zero code the chain input cannot cause a pull
  always_comb begin
    if (!zero_code && !force_blank)
      a_r5_ripple_ignored: assert (!own_pull);
  end

  // R6: without a pull from either side the node rests high
  always_comb begin
    if (!force_blank && !ext_pull && (chain_in || !zero_code))
      a_r6_node_high: assert (node_level);
  end
endmodule

// File: rtl/segdig_rb.sv
`timescale 1ns/1ps
module segdig_rb
  import segdig_pkg::*;
(
  input  logic [3:0] digit_code,
  input  logic       blank_force,
  input  logic       ripple_in,
  input  logic       dp_req,
  input  logic       ripple_pull_ext,
  output logic [6:0] seg,
  output logic       dp_on,
  output logic       ripple_pull,
  output logic       ripple_out
);
  seg_t raw_seg;
  logic zero_code;
  logic node_level;
  logic own_pull;
  logic lit;

  segdig_decode u_decode (
    .code      (digit_code),
    .raw_seg   (raw_seg),
    .zero_code (zero_code)
  );

  segdig_ripple u_ripple (
    .force_blank (blank_force),
    .chain_in    (ripple_in),
    .zero_code   (zero_code),
    .ext_pull    (ripple_pull_ext),
    .own_pull    (own_pull),
    .node_level  (node_level)
  );

  // the resolved node decides visibility; no storage anywhere (R9)
  assign lit         = node_level;
  assign seg         = lit ? raw_seg : '0;
  assign dp_on       = lit && dp_req;
  assign ripple_pull = own_pull;
  assign ripple_out  = node_level;

  // R3: forced blank darkens everything and pulls the node
  always_comb begin
    if (blank_force)
      a_r3_force_dark: assert (seg == '0 && !dp_on && ripple_pull && !ripple_out);
  end

  // R4: suppressed zero is dark and pulls
  always_comb begin
    if (digit_code == '0 && !ripple_in)
      a_r4_zero_suppress: assert (seg == '0 && ripple_pull);
  end

  // R7: a low node, whoever pulls it, leaves the digit dark
  always_comb begin
    if (!ripple_out)
      a_r7_low_node_dark: assert (seg == '0 && !dp_on);
  end

  // R8: decimal point lit only on request while visible
  always_comb begin
    if (dp_on)
      a_r8_dp_gated: assert (dp_req && ripple_out);
  end
endmodule

// File: tb/segdig_rb_test.sv
`timescale 1ns/1ps
module segdig_rb_test;
  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] digit_code;
  logic       blank_force, ripple_in, dp_req, ripple_pull_ext;
  logic [6:0] seg;
  logic       dp_on, ripple_pull, ripple_out;

  segdig_rb uut (
    .digit_code(digit_code), .blank_force(blank_force), .ripple_in(ripple_in),
    .dp_req(dp_req), .ripple_pull_ext(ripple_pull_ext),
    .seg(seg), .dp_on(dp_on), .ripple_pull(ripple_pull), .ripple_out(ripple_out)
  );

  // four-digit chain, index 3 is the most significant
  logic [3:0] cd [4];
  logic [6:0] cseg [4];
  logic       cdp [4];
  logic       cpull [4];
  logic       cout [4];
  logic       cin [4];
  assign cin[3] = 1'b0;     // suppress leading zeros
  assign cin[2] = cout[3];
  assign cin[1] = cout[2];
  assign cin[0] = 1'b1;     // units digit always shows

  for (genvar g = 0; g < 4; g++) begin : g_chain
    segdig_rb u_dig (
      .digit_code(cd[g]), .blank_force(1'b0), .ripple_in(cin[g]),
      .dp_req(1'b1), .ripple_pull_ext(1'b0),
      .seg(cseg[g]), .dp_on(cdp[g]), .ripple_pull(cpull[g]), .ripple_out(cout[g])
    );
  end

  // Bench's own glyph list, indexed by digit.
  function automatic logic [6:0] glyph(input int d);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    if (d > 9) return 7'h00;
    return t[d];
  endfunction

  // {req[3:0], code[3:0], force, rin, dpq, ext, seg[6:0], dp, pull, out}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {4'd1, 4'd5,  1'b0,1'b1,1'b1,1'b0, 7'h6D,1'b1,1'b0,1'b1}, // R1 five with dp
    {4'd6, 4'd0,  1'b0,1'b1,1'b0,1'b0, 7'h3F,1'b0,1'b0,1'b1}, // R6 zero shown
    {4'd4, 4'd0,  1'b0,1'b0,1'b1,1'b0, 7'h00,1'b0,1'b1,1'b0}, // R4 zero suppressed
    {4'd5, 4'd7,  1'b0,1'b0,1'b0,1'b0, 7'h07,1'b0,1'b0,1'b1}, // R5 ripple ignored
    {4'd3, 4'd9,  1'b1,1'b1,1'b1,1'b0, 7'h00,1'b0,1'b1,1'b0}, // R3 forced blank
    {4'd7, 4'd3,  1'b0,1'b1,1'b1,1'b1, 7'h00,1'b0,1'b0,1'b0}, // R7 external pull
    {4'd2, 4'd12, 1'b0,1'b0,1'b0,1'b0, 7'h00,1'b0,1'b0,1'b1}, // R2 invalid not zero
    {4'd3, 4'd0,  1'b1,1'b0,1'b1,1'b1, 7'h00,1'b0,1'b1,1'b0}, // R3 all pulls
    {4'd1, 4'd6,  1'b0,1'b1,1'b1,1'b0, 7'h7D,1'b1,1'b0,1'b1}, // R1 six with tail
    {4'd8, 4'd15, 1'b0,1'b1,1'b1,1'b0, 7'h00,1'b1,1'b0,1'b1}, // R8 dp on dark code
    {4'd3, 4'd8,  1'b1,1'b1,1'b0,1'b1, 7'h00,1'b0,1'b1,1'b0}, // R3 with ext
    {4'd5, 4'd1,  1'b0,1'b0,1'b1,1'b0, 7'h06,1'b1,1'b0,1'b1}  // R5 one with rin low
  };

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got seg=%h dp=%b pull=%b out=%b, expected seg=%h dp=%b pull=%b out=%b",
               req, got[9:3], got[2], got[1], got[0], exp[9:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic f, input logic ri,
                       input logic dq, input logic ex);
    @(negedge clk);
    digit_code = c; blank_force = f; ripple_in = ri; dp_req = dq; ripple_pull_ext = ex;
    #1;
  endtask

  function automatic logic [9:0] outs();
    return {seg, dp_on, ripple_pull, ripple_out};
  endfunction

  task automatic chain_check(input int n);
    int dig [4];
    bit lead;
    string tag;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      dig[i] = (n / (10 ** i)) % 10;
      cd[i]  = 4'(dig[i]);
    end
    #1;
    lead = 1'b1;
    for (int i = 3; i >= 0; i--) begin
      bit dark;
      if (dig[i] != 0) lead = 1'b0;
      dark = lead && (i != 0);
      tag = $sformatf("R4 chain %0d digit %0d", n, i);
      check(tag, {cseg[i], cdp[i], cpull[i], cout[i]},
            {dark ? 7'h00 : glyph(dig[i]), !dark, dark, !dark});
    end
  endtask

  initial begin
    digit_code = '0; blank_force = 1'b0; ripple_in = 1'b1; dp_req = 1'b0; ripple_pull_ext = 1'b0;
    for (int i = 0; i < 4; i++) cd[i] = '0;
    repeat (2) @(posedge clk);

    // idle state: zero shown, no pulls
    drive(4'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R6 idle", outs(), {7'h3F, 1'b0, 1'b0, 1'b1});

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      e = VEC[v];
      drive(e[17:14], e[13], e[12], e[11], e[10]);
      check($sformatf("R%0d vector %0d", e[21:18], v), outs(), e[9:0]);
    end

    // all sixteen codes, R1 and R2
    for (int c = 0; c < 16; c++) begin
      drive(4'(c), 1'b0, 1'b1, 1'b0, 1'b0);
      check(c < 10 ? $sformatf("R1 code %0d", c) : $sformatf("R2 code %0d", c),
            outs(), {glyph(c), 1'b0, 1'b0, 1'b1});
    end

    // R5: ripple_in swept on every non-zero code
    for (int c = 1; c < 16; c++) begin
      drive(4'(c), 1'b0, 1'b0, 1'b1, 1'b0);
      check($sformatf("R5 code %0d", c), outs(), {glyph(c), 1'b1, 1'b0, 1'b1});
    end

    // R7 / R8: external pull on each visible digit kills dp, own pull stays low
    for (int c = 0; c < 10; c++) begin
      drive(4'(c), 1'b0, 1'b1, 1'b1, 1'b1);
      check($sformatf("R7 ext code %0d", c), outs(), {7'h00, 1'b0, 1'b0, 1'b0});
      drive(4'(c), 1'b0, 1'b1, 1'b1, 1'b0);
      check($sformatf("R8 restore code %0d", c), outs(), {glyph(c), 1'b1, 1'b0, 1'b1});
    end

    // R9: forced blank toggled every cycle
    for (int k = 0; k < 8; k++) begin
      drive(4'd8, k[0], 1'b1, 1'b1, 1'b0);
      check($sformatf("R9 toggle %0d", k), outs(),
            k[0] ? {7'h00, 1'b0, 1'b1, 1'b0} : {7'h7F, 1'b1, 1'b0, 1'b1});
    end

    // four-digit chain, R4 and R6
    chain_check(0);
    chain_check(40);
    chain_check(305);
    chain_check(7);
    chain_check(1000);
    chain_check(9009);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule